// File: doc/BRIEF.md
# Host-to-Microcontroller Mailbox FIFO Register Block

This block sits between a host register bus and an 8-bit byte channel that leads to a system microcontroller. The host sees three 32-bit registers inside an 8-word window: an interrupt register, a data register and a status register. Host data writes feed a transmit FIFO. A small drain state machine passes the FIFO contents to the device side as a valid/ready byte stream. Bytes arriving from the device fill a receive FIFO, which the host empties by reading the data register.

Four events are tracked: transmit side empty, transmit FIFO not full, receive FIFO not empty and receive overflow. Each event has a sticky flag that the host clears by writing a one to it. Each event also has a mask bit, and the interrupt output is raised whenever a set flag has its mask bit enabled. The device side of the receive path has no backpressure. A byte that arrives while the receive FIFO is full is dropped, and the overflow flag is set.

The transmit drain machine has two states. In `DR_IDLE` it holds `tx_valid` low and waits. The transition IDLE→OFFER (FIFO not empty) pops the head of the FIFO into the output register. In `DR_OFFER` it drives `tx_valid` high. The transition OFFER→OFFER (`tx_ready` high and FIFO not empty) pops the next byte during the handshake. The transition OFFER→IDLE (`tx_ready` high and FIFO empty) completes the last byte. While `tx_ready` is low the machine stays in OFFER and holds its byte.

Top module: `mcu_mbox_regs`

## Requirements
- R1: Word offset 0 is the interrupt register, 1 is the data register and 2 is the status register. Offsets 3 to 7 read as zero, and writes to them have no effect.
- R2: Interrupt register bits [3:0] mirror the four sticky flags (bit 0 transmit empty, bit 1 transmit not full, bit 2 receive not empty, bit 3 receive overflow). Bits [7:4] are the mask bits in the same order and are writable. Writes to bits [3:0] of this register are ignored. All other bits read as zero.
- R3: `irq` is high exactly when some flag is set and its mask bit is 1.
- R4: Status register bits [3:0] hold the sticky flags in the R2 order. Each flag is set in the cycle after its condition is seen. The conditions are: transmit FIFO and drain output both empty; transmit FIFO holding fewer than FIFO_DEPTH bytes; receive FIFO not empty.
- R5: A status write clears each flag whose written bit is 1. A flag whose condition still holds in that cycle stays set.
- R6: A data write pushes bits [15:8] into the transmit FIFO. The write is ignored when the FIFO is full. Bytes leave on `tx_byte` in write order, one per `tx_valid`/`tx_ready` handshake.
- R7: A data read returns the oldest received byte in bits [15:8], with all other bits zero, and pops it. A data read of an empty receive FIFO returns zero and pops nothing. Read data appears on `bus_rdata` after the clock edge of the read strobe and is held until the next read.
- R8: When `rx_valid` is high while the receive FIFO is full and no pop happens in that cycle, the byte is dropped and the overflow flag (bit 3) is set.
- R9: After reset, `bus_rdata` is 0, `irq` is 0, `tx_valid` is 0, all masks are 0 and all flags are 0.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_byte` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset in the 8-word window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Byte offered to the device |
| tx_ready | input | 1 | Device accepts the offered byte |
| tx_byte | output | 8 | Byte toward the device |
| rx_valid | input | 1 | Device delivers a byte this cycle |
| rx_byte | input | 8 | Byte from the device |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume the following about the inputs:
- Every host access is a single-cycle strobe.
- A read result is looked at only after the edge of its strobe.
- `rx_valid` marks exactly one byte per cycle it is high, with no handshake back.

The hold check on the drain output places no limit on when `tx_ready` may change. The directed tasks keep to these assumptions by issuing one access every two cycles and pushing receive bytes as one-cycle pulses or back-to-back bursts. They never write the data register in the same cycle that the drain pops from a full transmit FIFO, so that the ignore-on-full case stays unambiguous.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned WIN_AW  = 3;
    localparam int unsigned LANE_LO = 8;
    localparam int unsigned NFLG    = 4;

    localparam logic [WIN_AW-1:0] OFF_IRQ  = 3'd0;
    localparam logic [WIN_AW-1:0] OFF_DATA = 3'd1;
    localparam logic [WIN_AW-1:0] OFF_STAT = 3'd2;

    localparam int unsigned FLG_TXE  = 0;
    localparam int unsigned FLG_TXNF = 1;
    localparam int unsigned FLG_RXNE = 2;
    localparam int unsigned FLG_RXOV = 3;

    typedef enum logic {
        DR_IDLE  = 1'b0,
        DR_OFFER = 1'b1
    } drain_state_e;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [W-1:0]                   push_data,
    input  logic                           pop,
    output logic [W-1:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           empty,
    output logic                           push_ok
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign push_ok = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !do_pop)      count <= count + 1'b1;
            else if (!push_ok && do_pop) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/mbx_tx_drain.sv
module mbx_tx_drain
    import mbx_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_head,
    output logic         fifo_pop,
    output logic         tx_valid,
    input  logic         tx_ready,
    output logic [W-1:0] tx_byte
);
    drain_state_e state_q, state_d;
    logic [W-1:0] hold_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DR_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        fifo_pop = 1'b0;
        tx_valid = 1'b0;
        unique case (state_q)
            DR_IDLE: begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    state_d  = DR_OFFER;
                end
            end
            DR_OFFER: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    if (!fifo_empty) fifo_pop = 1'b1;
                    else             state_d  = DR_IDLE;
                end
            end
            default: state_d = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (fifo_pop) hold_q <= fifo_head;
    end

    assign tx_byte = hold_q;
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_cond,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= (flags[i] & ~clr_req[i]) | set_cond[i];
        end
    end
endmodule

// File: rtl/mcu_mbox_regs.sv
module mcu_mbox_regs
    import mbx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              irq
);
    localparam int unsigned CW = $clog2(FIFO_DEPTH+1);

    logic rd_stb, wr_stb;
    logic tx_push, tx_pop, tx_full, tx_empty, tx_push_ok_unused;
    logic rx_pop, rx_full, rx_empty, rx_push_ok;
    logic [BYTE_W-1:0] tx_head, rx_head;
    logic [CW-1:0]     tx_cnt, rx_cnt_unused;
    logic [NFLG-1:0]   flag_q, set_cond, clr_req, mask_q;
    logic [BUS_W-1:0]  rd_val;
    logic              ov_event;
    logic              wdata_hi_unused;

    assign wdata_hi_unused = ^bus_wdata[BUS_W-1:LANE_LO+BYTE_W];

    assign rd_stb  = bus_sel && !bus_we;
    assign wr_stb  = bus_sel &&  bus_we;
    assign tx_push = wr_stb && (bus_addr == OFF_DATA);
    assign rx_pop  = rd_stb && (bus_addr == OFF_DATA);
    assign clr_req = (wr_stb && bus_addr == OFF_STAT) ? bus_wdata[NFLG-1:0] : '0;

    mbx_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(bus_wdata[LANE_LO +: BYTE_W]),
        .pop(tx_pop), .head(tx_head), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty), .push_ok(tx_push_ok_unused)
    );

    mbx_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_valid), .push_data(rx_byte),
        .pop(rx_pop), .head(rx_head), .count(rx_cnt_unused),
        .full(rx_full), .empty(rx_empty), .push_ok(rx_push_ok)
    );

    mbx_tx_drain #(.W(BYTE_W)) u_drain (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(tx_empty), .fifo_head(tx_head), .fifo_pop(tx_pop),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte)
    );

    assign ov_event = rx_valid && !rx_push_ok;

    always_comb begin
        set_cond           = '0;
        set_cond[FLG_TXE]  = tx_empty && !tx_valid;
        set_cond[FLG_TXNF] = !tx_full;
        set_cond[FLG_RXNE] = !rx_empty;
        set_cond[FLG_RXOV] = ov_event;
    end

    mbx_flags #(.N(NFLG)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_cond(set_cond), .clr_req(clr_req), .flags(flag_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_stb && bus_addr == OFF_IRQ)
            mask_q <= bus_wdata[2*NFLG-1:NFLG];
    end

    always_comb begin
        rd_val = '0;
        case (bus_addr)
            OFF_IRQ:  rd_val[2*NFLG-1:0] = {mask_q, flag_q};
            OFF_DATA: if (!rx_empty) rd_val[LANE_LO +: BYTE_W] = rx_head;
            OFF_STAT: rd_val[NFLG-1:0] = flag_q;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_stb) bus_rdata <= rd_val;
    end

    assign irq = |(flag_q & mask_q);
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int unsigned CW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [WIN_AW-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              rx_valid,
    input logic              rx_full,
    input logic              rx_empty,
    input logic              tx_full,
    input logic              tx_pop,
    input logic [CW-1:0]     tx_cnt,
    input logic [NFLG-1:0]   flag_q,
    input logic              ov_event
);
    // R10: the offered byte is held until accepted
    assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

    // R7: reading an empty receive FIFO returns zero
    assert_rx_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_we && bus_addr == OFF_DATA && rx_empty |=> bus_rdata == '0);

    // R8: a delivery into a full FIFO without a pop raises overflow
    assert_rx_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_full && !(bus_sel && !bus_we && bus_addr == OFF_DATA)
        |=> flag_q[FLG_RXOV]);

    // R5: write-one clears overflow when no new overflow occurs
    assert_w1c_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_we && bus_addr == OFF_STAT && bus_wdata[FLG_RXOV] && !ov_event
        |=> !flag_q[FLG_RXOV]);

    // R6: a write to a full transmit FIFO leaves its occupancy alone
    assert_tx_full_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_we && bus_addr == OFF_DATA && tx_full && !tx_pop
        |=> $stable(tx_cnt));

    // R1: unused words read zero
    assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_we && bus_addr > OFF_STAT |=> bus_rdata == '0);
endmodule

bind mcu_mbox_regs mbx_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_full(tx_full), .tx_pop(tx_pop), .tx_cnt(tx_cnt),
    .flag_q(flag_q), .ov_event(ov_event)
);

// File: tb/sim_mcu_mbox_regs.sv
`timescale 1ns/1ps
module sim_mcu_mbox_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        irq;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    mcu_mbox_regs u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rx_burst(input logic [7:0] base, input int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1; rx_byte = base + 8'(i);
            @(negedge clk);
        end
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R9 rdata after reset", bus_rdata, 32'h0);
        chk("R9 irq after reset", {31'h0, irq}, 32'h0);
        chk("R9 tx_valid after reset", {31'h0, tx_valid}, 32'h0);
        idle(3);
        bus_rd(3'd2, d);
        chk("R4 status after idle", d, 32'h3);
        bus_rd(3'd0, d);
        chk("R2 interrupt reg after idle", d, 32'h3);
    endtask

    task automatic t_unused();
        logic [31:0] d;
        bus_rd(3'd5, d);
        chk("R1 offset 5 reads zero", d, 32'h0);
        bus_rd(3'd3, d);
        chk("R1 offset 3 reads zero", d, 32'h0);
        bus_wr(3'd7, 32'hFFFF_FFFF);
        bus_rd(3'd0, d);
        chk("R1 write to offset 7 no effect", d, 32'h3);
        bus_wr(3'd0, 32'h0000_000F);
        bus_rd(3'd0, d);
        chk("R2 request bits not writable", d, 32'h3);
    endtask

    task automatic t_tx();
        logic [31:0] d;
        int n;
        tx_ready = 1'b0;
        for (int i = 0; i < 10; i++)
            bus_wr(3'd1, {16'h1234, 8'hA0 + 8'(i), 8'hCD});
        idle(2);
        chk("R10 tx_valid while stalled", {31'h0, tx_valid}, 32'h1);
        chk("R10 first byte offered", {24'h0, tx_byte}, 32'hA0);
        bus_wr(3'd2, 32'h3);
        idle(2);
        bus_rd(3'd2, d);
        chk("R5 tx flags cleared while full", d & 32'h3, 32'h0);
        idle(3);
        chk("R10 byte held while stalled", {24'h0, tx_byte}, 32'hA0);
        @(negedge clk);
        tx_ready = 1'b1;
        n = 0;
        while (tx_valid && n < 20) begin
            chk("R6 tx byte order", {24'h0, tx_byte}, 32'hA0 + 32'(n));
            n++;
            @(negedge clk);
        end
        tx_ready = 1'b0;
        chk("R6 tx count with full drop", n, 9);
        idle(2);
        bus_rd(3'd2, d);
        chk("R4 tx flags set after drain", d & 32'h3, 32'h3);
    endtask

    task automatic t_rx();
        logic [31:0] d;
        rx_burst(8'h11, 1);
        rx_burst(8'h22, 1);
        rx_burst(8'h33, 1);
        idle(2);
        bus_rd(3'd2, d);
        chk("R4 rx not empty flag", d & 32'h4, 32'h4);
        for (int i = 0; i < 3; i++) begin
            bus_rd(3'd1, d);
            chk("R7 rx byte lane", d, {16'h0, 8'h11 * 8'(i + 1), 8'h0});
        end
        bus_rd(3'd1, d);
        chk("R7 empty read zero", d, 32'h0);
        bus_wr(3'd2, 32'h4);
        idle(2);
        bus_rd(3'd2, d);
        chk("R5 rx flag cleared when empty", d & 32'h4, 32'h0);
        rx_burst(8'h44, 1);
        idle(2);
        bus_wr(3'd2, 32'h4);
        idle(2);
        bus_rd(3'd2, d);
        chk("R5 rx flag stays while not empty", d & 32'h4, 32'h4);
        bus_rd(3'd1, d);
        chk("R7 held byte still readable", d, 32'h0000_4400);
        bus_wr(3'd2, 32'h4);
        idle(2);
    endtask

    task automatic t_ovf();
        logic [31:0] d;
        bus_rd(3'd2, d);
        chk("R8 no overflow before burst", d & 32'h8, 32'h0);
        rx_burst(8'h50, 9);
        idle(2);
        bus_rd(3'd2, d);
        chk("R8 overflow flag set", d & 32'h8, 32'h8);
        for (int i = 0; i < 8; i++) begin
            bus_rd(3'd1, d);
            chk("R8 kept bytes in order", d, {16'h0, 8'h50 + 8'(i), 8'h0});
        end
        bus_rd(3'd1, d);
        chk("R8 ninth byte dropped", d, 32'h0);
        bus_wr(3'd2, 32'hC);
        idle(2);
        bus_rd(3'd2, d);
        chk("R5 overflow cleared", d & 32'hC, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        bus_wr(3'd2, 32'hF);
        idle(2);
        bus_wr(3'd0, 32'h40);
        idle(1);
        chk("R3 masked rx event idle", {31'h0, irq}, 32'h0);
        rx_burst(8'h77, 1);
        idle(2);
        chk("R3 rx event raises irq", {31'h0, irq}, 32'h1);
        bus_rd(3'd0, d);
        chk("R2 mask and flags readback", d, 32'h47);
        bus_rd(3'd1, d);
        bus_wr(3'd2, 32'h4);
        idle(2);
        chk("R3 irq drops after clear", {31'h0, irq}, 32'h0);
        bus_wr(3'd0, 32'h10);
        idle(1);
        chk("R3 tx empty mask raises irq", {31'h0, irq}, 32'h1);
        bus_wr(3'd0, 32'h0);
        idle(1);
        chk("R3 all masked off", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unused();
        t_tx();
        t_rx();
        t_ovf();
        t_irq();
        idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule